// File: doc/BRIEF.md
# Radio Control Register Bank with SPI Target Port

This block is a serial-port target that holds a small set of radio control registers. A host drives it through a four-wire SPI link in mode 0. It is used to verify the serial master above it, and it also serves as a small control-plane peripheral. Each transaction starts with an address header in one of two forms. The short form carries a 6-bit address. The long form carries a 10-bit address. A header is followed by one data byte, which is either written into the selected register or shifted back out to the host.

Most registers are plain storage. A few have side effects. Three reset command bits clear themselves after a fixed time. A signal-strength request runs a timed measurement and then raises a ready flag. A transmit-result stub loads a status register and an interrupt flag register. The interrupt flag register clears when it is read. An active-low interrupt line is driven low while any enabled flag is set.

Top module: `radio_regbank_spi`

## Requirements
- R1: Short frame. The first byte is `0 a5 a4 a3 a2 a1 a0 w`, where w=1 means write and w=0 means read, and the second byte is the data. The plain short registers at addresses 0x00 to PLAIN_SHORT-1 store every written byte and read it back. MISO changes on falling SCK, most significant bit first, and read data starts in the first bit after the header.
- R2: Long frame. Byte 0 is `1 a9..a3` and byte 1 is `a2 a1 a0 w 0000`, where w has the same meaning as in R1. Byte 2 is the data. The plain long registers at 0x200 to 0x200+PLAIN_LONG-1 store and return their bytes.
- R3: Short register 0x2A holds three reset command bits. Bit 2 is power management, bit 1 is baseband and bit 0 is MAC. Writing 1 to a bit drives the matching `soft_rst` output high, and the bit reads back as 1 for RST_CYCLES clock cycles. After that it returns to 0. Writing 0 to a bit has no effect.
- R4: In short register 0x3E, bit 7 is the measurement request and bit 0 is the ready flag. Writing bit 7 as 1 sets the request and clears ready. After SYMBOL_CYCLES*AVG_SYMBOLS cycles the request clears and ready sets.
- R5: Long register 0x210 returns the `rssi_level` sample taken when a measurement completes. It keeps that value while the input changes, and writes to it are ignored.
- R6: In short register 0x31, bit 3 is set by `rx_frame_evt` and bit 0 is set by `tx_done_evt`. Reading the register returns the flags and clears them. If an event arrives in the same cycle as the clear, its flag stays set.
- R7: Short register 0x32 is an interrupt mask. It resets to 0xFF. Its bit 3 and bit 0 enable the matching flags when 0. `irq_n` is low exactly while an enabled flag is set.
- R8: Short register 0x24 is loaded on `tx_done_evt`. Bit 0 is set to 1 when the transmission failed. Bit 5 is set to 1 only when it failed on a busy channel. For a retry-exhausted failure, bit 5 is 0.
- R9: Writing short register 0x1B with bit 0 set gives a one-cycle `tx_start` pulse. Writing it with bit 0 clear gives no pulse. The register reads as 0x00.
- R10: Short register 0x36 keeps bit 2 only. Bit 2 drives `rf_sm_rst`, and the other bits read as 0.
- R11: Any address not listed above reads as 0x00, and writes to it change nothing.
- R12: After reset, `spi_miso` is 0, `irq_n` is 1, `tx_start`, `rf_sm_rst` and `soft_rst` are 0, the mask reads 0xFF, and all other registers read 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, which oversamples the serial pins |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_sck | input | 1 | Serial clock, idle low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| rssi_level | input | 8 | Synthetic signal-strength sample |
| rx_frame_evt | input | 1 | One-cycle pulse for a received packet |
| tx_done_evt | input | 1 | One-cycle pulse when a transmission ends |
| tx_failed | input | 1 | Failure qualifier for `tx_done_evt` |
| tx_chan_busy | input | 1 | Busy-channel qualifier for a failure |
| tx_start | output | 1 | One-cycle transmit trigger |
| rf_sm_rst | output | 1 | RF state-machine reset level |
| soft_rst | output | 3 | Self-clearing reset lines: bit 2 power, bit 1 baseband, bit 0 MAC |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The hardest case to reach from the ports is an event that lands in the exact cycle in which a read of the flag register clears it. Only one clock edge per read triggers the clear, and that edge sits behind the synchronizers on the serial pins. The stimulus raises SCK for the last header bit of a flag-register read. It then counts the known synchronizer and decode delay in system clocks and pulses `rx_frame_evt` for one cycle aligned with the clear. The expected result is that this read returns 0x00 and the next read returns the receive flag.

// File: rtl/rrb_pkg.sv
// Shared address map, bit positions and address type for the radio
// register bank. Assumes short addresses are 6 bits and long are 10 bits.
package rrb_pkg;
    localparam int ADDR_W   = 10;
    localparam int NUM_RST  = 3;

    localparam logic [5:0] SA_TXCTL   = 6'h1B;
    localparam logic [5:0] SA_TXSTAT  = 6'h24;
    localparam logic [5:0] SA_SOFTRST = 6'h2A;
    localparam logic [5:0] SA_INTSTAT = 6'h31;
    localparam logic [5:0] SA_INTMASK = 6'h32;
    localparam logic [5:0] SA_RFCTL   = 6'h36;
    localparam logic [5:0] SA_RSSICTL = 6'h3E;

    localparam logic [9:0] LA_PLAIN_BASE = 10'h200;
    localparam logic [9:0] LA_RSSI       = 10'h210;

    localparam int INT_RX_BIT   = 3;
    localparam int INT_TX_BIT   = 0;
    localparam int TXS_FAIL_BIT = 0;
    localparam int TXS_BUSY_BIT = 5;
    localparam int RF_SMRST_BIT = 2;
    localparam int RSSI_REQ_BIT = 7;
    localparam int RSSI_RDY_BIT = 0;
    localparam int TXCTL_GO_BIT = 0;

    typedef struct packed {
        logic             is_long;
        logic [ADDR_W-1:0] addr;
    } reg_addr_t;
endpackage

// File: rtl/rrb_pulse_timer.sv
// Retriggerable countdown: busy is high for CYCLES clocks after start.
// Assumes CYCLES >= 1.
module rrb_pulse_timer #(
    parameter int CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_q;

    // Load on start, otherwise count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (start)        cnt_q <= CW'(CYCLES);
        else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);
    end

    assign busy = (cnt_q != '0);

    assert_busy_after_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);
    assert_ends_after_last_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CW'(1) && !start) |=> !busy);
endmodule

// File: rtl/rrb_spi_frame.sv
// Mode-0 SPI target frame engine, oversampled by clk. It decodes the short
// and long headers and raises a one-cycle wr_en or rd_req.
// Assumes each SCK half period spans at least five clk cycles.
module rrb_spi_frame
    import rrb_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sck,
    input  logic       cs_n,
    input  logic       mosi,
    output logic       miso,
    output logic       wr_en,
    output logic       rd_req,
    output reg_addr_t  addr,
    output logic [7:0] wr_data,
    input  logic [7:0] rd_data
);
    localparam logic [4:0] BITS_MAX = 5'd24;

    logic [1:0] sck_sy, cs_sy, mosi_sy;
    logic       sck_d;
    logic       sck_s, cs_s, mosi_s, rise, fall;
    logic [4:0] bit_cnt;
    logic [6:0] rx_sh;
    logic [6:0] hdr_hi;
    logic [7:0] tx_sh;
    logic [7:0] new_byte;
    logic       is_wr;

    // Two-flop synchronizers plus an edge-detect delay for SCK.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_sy  <= '0;
            cs_sy   <= 2'b11;
            mosi_sy <= '0;
            sck_d   <= 1'b0;
        end else begin
            sck_sy  <= {sck_sy[0], sck};
            cs_sy   <= {cs_sy[0], cs_n};
            mosi_sy <= {mosi_sy[0], mosi};
            sck_d   <= sck_sy[1];
        end
    end

    assign sck_s    = sck_sy[1];
    assign cs_s     = cs_sy[1];
    assign mosi_s   = mosi_sy[1];
    assign rise     = sck_s & ~sck_d;
    assign fall     = ~sck_s & sck_d;
    assign new_byte = {rx_sh, mosi_s};

    // Bit counting, header decode, access strobes and MISO shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            rx_sh   <= '0;
            hdr_hi  <= '0;
            tx_sh   <= '0;
            miso    <= 1'b0;
            is_wr   <= 1'b0;
            addr    <= '0;
            wr_data <= '0;
            wr_en   <= 1'b0;
            rd_req  <= 1'b0;
        end else begin
            wr_en  <= 1'b0;
            rd_req <= 1'b0;
            if (cs_s) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
                miso    <= 1'b0;
            end else begin
                if (rise && bit_cnt != BITS_MAX) begin
                    rx_sh   <= new_byte[6:0];
                    bit_cnt <= bit_cnt + 5'd1;
                    case (bit_cnt)
                        5'd7: begin
                            hdr_hi <= new_byte[6:0];
                            if (!new_byte[7]) begin
                                addr   <= '{is_long: 1'b0, addr: {4'b0, new_byte[6:1]}};
                                is_wr  <= new_byte[0];
                                rd_req <= ~new_byte[0];
                            end else begin
                                addr  <= '{is_long: 1'b1, addr: '0};
                                is_wr <= 1'b0;
                            end
                        end
                        5'd15: begin
                            if (addr.is_long) begin
                                addr   <= '{is_long: 1'b1, addr: {hdr_hi, new_byte[7:5]}};
                                is_wr  <= new_byte[4];
                                rd_req <= ~new_byte[4];
                            end else if (is_wr) begin
                                wr_en   <= 1'b1;
                                wr_data <= new_byte;
                            end
                        end
                        5'd23: begin
                            if (addr.is_long && is_wr) begin
                                wr_en   <= 1'b1;
                                wr_data <= new_byte;
                            end
                        end
                        default: ;
                    endcase
                end
                if (rd_req) begin
                    tx_sh <= rd_data;
                end else if (fall) begin
                    miso  <= tx_sh[7];
                    tx_sh <= {tx_sh[6:0], 1'b0};
                end
            end
        end
    end

    assert_read_strobe_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);
    assert_no_rd_with_wr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !rd_req);
endmodule

// File: rtl/rrb_reg_core.sv
// Register storage and side effects: plain short and long banks, reset
// commands, the measurement handshake, interrupt flags and mask, transmit
// status and control, and RF control. Assumes wr_en and rd_req are one-cycle
// strobes with addr stable while they are high.
module rrb_reg_core
    import rrb_pkg::*;
#(
    parameter int PLAIN_SHORT = 8,
    parameter int PLAIN_LONG  = 8,
    parameter int RST_CYCLES  = 300,
    parameter int RSSI_CYCLES = 320
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_req,
    input  reg_addr_t        addr,
    input  logic [7:0]       wr_data,
    output logic [7:0]       rd_data,
    input  logic [7:0]       rssi_level,
    input  logic             rx_evt,
    input  logic             tx_done,
    input  logic             tx_failed,
    input  logic             tx_chan_busy,
    output logic             tx_start,
    output logic             rf_sm_rst,
    output logic [NUM_RST-1:0] soft_rst,
    output logic             irq_n
);
    localparam int KW = ADDR_W + 1;

    logic [KW-1:0] key;
    logic hit_txctl, hit_txstat, hit_softrst, hit_intstat, hit_intmask;
    logic hit_rfctl, hit_rssictl, hit_rssi;
    logic [7:0] sh_mem [PLAIN_SHORT];
    logic [7:0] lg_mem [PLAIN_LONG];
    logic       rssi_start, rssi_busy, rssi_busy_d, rssi_rdy;
    logic [7:0] rssi_val;
    logic       int_rx, int_tx, rd_clear;
    logic [7:0] int_mask;
    logic       txs_fail, txs_busy;

    assign key         = {addr.is_long, addr.addr};
    assign hit_txctl   = key == {1'b0, 4'b0, SA_TXCTL};
    assign hit_txstat  = key == {1'b0, 4'b0, SA_TXSTAT};
    assign hit_softrst = key == {1'b0, 4'b0, SA_SOFTRST};
    assign hit_intstat = key == {1'b0, 4'b0, SA_INTSTAT};
    assign hit_intmask = key == {1'b0, 4'b0, SA_INTMASK};
    assign hit_rfctl   = key == {1'b0, 4'b0, SA_RFCTL};
    assign hit_rssictl = key == {1'b0, 4'b0, SA_RSSICTL};
    assign hit_rssi    = key == {1'b1, LA_RSSI};

    // Plain short and long storage, one register per generated slot.
    for (genvar i = 0; i < PLAIN_SHORT; i++) begin : g_sh
        always_ff @(posedge clk) begin
            if (!rst_n) sh_mem[i] <= '0;
            else if (wr_en && key == {1'b0, ADDR_W'(i)}) sh_mem[i] <= wr_data;
        end
    end
    for (genvar i = 0; i < PLAIN_LONG; i++) begin : g_lg
        always_ff @(posedge clk) begin
            if (!rst_n) lg_mem[i] <= '0;
            else if (wr_en && key == {1'b1, LA_PLAIN_BASE + ADDR_W'(i)}) lg_mem[i] <= wr_data;
        end
    end

    // Self-clearing reset command bits, one timer per bit.
    for (genvar k = 0; k < NUM_RST; k++) begin : g_rst
        rrb_pulse_timer #(.CYCLES(RST_CYCLES)) u_tmr (
            .clk   (clk),
            .rst_n (rst_n),
            .start (wr_en && hit_softrst && wr_data[k]),
            .busy  (soft_rst[k])
        );
    end

    // Measurement window timer.
    assign rssi_start = wr_en && hit_rssictl && wr_data[RSSI_REQ_BIT];
    rrb_pulse_timer #(.CYCLES(RSSI_CYCLES)) u_rssi_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (rssi_start),
        .busy  (rssi_busy)
    );

    // Ready flag and sample capture at the end of the window.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rssi_busy_d <= 1'b0;
            rssi_rdy    <= 1'b0;
            rssi_val    <= '0;
        end else begin
            rssi_busy_d <= rssi_busy;
            if (rssi_start) begin
                rssi_rdy <= 1'b0;
            end else if (rssi_busy_d && !rssi_busy) begin
                rssi_rdy <= 1'b1;
                rssi_val <= rssi_level;
            end
        end
    end

    // Interrupt flags: read clears, a coincident event wins.
    assign rd_clear = rd_req && hit_intstat;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_rx <= 1'b0;
            int_tx <= 1'b0;
        end else if (rd_clear) begin
            int_rx <= rx_evt;
            int_tx <= tx_done;
        end else begin
            int_rx <= int_rx | rx_evt;
            int_tx <= int_tx | tx_done;
        end
    end

    // Mask, transmit status, transmit trigger and RF control.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            int_mask  <= 8'hFF;
            txs_fail  <= 1'b0;
            txs_busy  <= 1'b0;
            tx_start  <= 1'b0;
            rf_sm_rst <= 1'b0;
        end else begin
            if (wr_en && hit_intmask) int_mask <= wr_data;
            if (tx_done) begin
                txs_fail <= tx_failed;
                txs_busy <= tx_failed & tx_chan_busy;
            end
            tx_start <= wr_en && hit_txctl && wr_data[TXCTL_GO_BIT];
            if (wr_en && hit_rfctl) rf_sm_rst <= wr_data[RF_SMRST_BIT];
        end
    end

    assign irq_n = !((int_rx && !int_mask[INT_RX_BIT]) || (int_tx && !int_mask[INT_TX_BIT]));

    // Read data multiplexer; unmapped keys return zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < PLAIN_SHORT; i++)
            if (key == {1'b0, ADDR_W'(i)}) rd_data = sh_mem[i];
        for (int i = 0; i < PLAIN_LONG; i++)
            if (key == {1'b1, LA_PLAIN_BASE + ADDR_W'(i)}) rd_data = lg_mem[i];
        if (hit_softrst) rd_data = 8'(soft_rst);
        if (hit_rssictl) begin
            rd_data[RSSI_REQ_BIT] = rssi_busy;
            rd_data[RSSI_RDY_BIT] = rssi_rdy;
        end
        if (hit_rssi)    rd_data = rssi_val;
        if (hit_intstat) begin
            rd_data[INT_RX_BIT] = int_rx;
            rd_data[INT_TX_BIT] = int_tx;
        end
        if (hit_intmask) rd_data = int_mask;
        if (hit_txstat) begin
            rd_data[TXS_FAIL_BIT] = txs_fail;
            rd_data[TXS_BUSY_BIT] = txs_busy;
        end
        if (hit_rfctl)   rd_data[RF_SMRST_BIT] = rf_sm_rst;
    end

    assert_rssi_flags_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(rssi_busy && rssi_rdy));
    assert_rx_evt_sets_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_evt |=> int_rx);
    assert_enabled_flag_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_evt && !int_mask[INT_RX_BIT] && !(wr_en && hit_intmask)) |=> !irq_n);
    assert_busy_needs_fail_R8: assert property (@(posedge clk) disable iff (!rst_n)
        txs_busy |-> txs_fail);
    assert_start_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tx_start |=> !tx_start);
    assert_rf_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && hit_rfctl) |=> $stable(rf_sm_rst));
endmodule

// File: rtl/radio_regbank_spi.sv
// Top level of the radio control register bank: SPI frame engine plus
// register core. Assumes clk runs at least ten times faster than SCK.
module radio_regbank_spi
    import rrb_pkg::*;
#(
    parameter int PLAIN_SHORT   = 8,
    parameter int PLAIN_LONG    = 8,
    parameter int RST_CYCLES    = 300,
    parameter int SYMBOL_CYCLES = 40,
    parameter int AVG_SYMBOLS   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_sck,
    input  logic       spi_cs_n,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic [7:0] rssi_level,
    input  logic       rx_frame_evt,
    input  logic       tx_done_evt,
    input  logic       tx_failed,
    input  logic       tx_chan_busy,
    output logic       tx_start,
    output logic       rf_sm_rst,
    output logic [2:0] soft_rst,
    output logic       irq_n
);
    localparam int RSSI_CYCLES = SYMBOL_CYCLES * AVG_SYMBOLS;

    logic       wr_en, rd_req;
    reg_addr_t  acc_addr;
    logic [7:0] wr_data, rd_data;

    rrb_spi_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck     (spi_sck),
        .cs_n    (spi_cs_n),
        .mosi    (spi_mosi),
        .miso    (spi_miso),
        .wr_en   (wr_en),
        .rd_req  (rd_req),
        .addr    (acc_addr),
        .wr_data (wr_data),
        .rd_data (rd_data)
    );

    rrb_reg_core #(
        .PLAIN_SHORT (PLAIN_SHORT),
        .PLAIN_LONG  (PLAIN_LONG),
        .RST_CYCLES  (RST_CYCLES),
        .RSSI_CYCLES (RSSI_CYCLES)
    ) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (wr_en),
        .rd_req       (rd_req),
        .addr         (acc_addr),
        .wr_data      (wr_data),
        .rd_data      (rd_data),
        .rssi_level   (rssi_level),
        .rx_evt       (rx_frame_evt),
        .tx_done      (tx_done_evt),
        .tx_failed    (tx_failed),
        .tx_chan_busy (tx_chan_busy),
        .tx_start     (tx_start),
        .rf_sm_rst    (rf_sm_rst),
        .soft_rst     (soft_rst),
        .irq_n        (irq_n)
    );
endmodule

// File: tb/radio_regbank_spi_tb_top.sv
// Directed bench: each task drives one scenario and checks its own results.
module radio_regbank_spi_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 6;
    localparam int WDOG       = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso;
    logic [7:0] rssi_level = 8'h00;
    logic rx_evt = 1'b0, tx_done = 1'b0, tx_failed = 1'b0, tx_busy = 1'b0;
    logic tx_start, rf_sm_rst, irq_n;
    logic [2:0] soft_rst;

    int n_chk = 0;
    int n_bad = 0;
    int n_start = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    radio_regbank_spi dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_sck      (sck),
        .spi_cs_n     (cs_n),
        .spi_mosi     (mosi),
        .spi_miso     (miso),
        .rssi_level   (rssi_level),
        .rx_frame_evt (rx_evt),
        .tx_done_evt  (tx_done),
        .tx_failed    (tx_failed),
        .tx_chan_busy (tx_busy),
        .tx_start     (tx_start),
        .rf_sm_rst    (rf_sm_rst),
        .soft_rst     (soft_rst),
        .irq_n        (irq_n)
    );

    always @(posedge clk) if (tx_start) n_start++;

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx, input bit hook);
        for (int i = 7; i >= 0; i--) begin
            mosi = tx[i];
            repeat (HALF) @(negedge clk);
            rx[i] = miso;
            sck = 1'b1;
            if (hook && i == 0) begin
                repeat (3) @(negedge clk);
                rx_evt = 1'b1;
                @(negedge clk);
                rx_evt = 1'b0;
                repeat (HALF - 4) @(negedge clk);
            end else begin
                repeat (HALF) @(negedge clk);
            end
            sck = 1'b0;
        end
    endtask

    task automatic frame(input int n, input logic [7:0] b0, input logic [7:0] b1,
                         input logic [7:0] b2, input bit hook, output logic [7:0] got);
        logic [7:0] r;
        cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
        spi_byte(b0, r, hook && n == 2);
        spi_byte(b1, r, hook && n == 3);
        got = r;
        if (n == 3) begin
            spi_byte(b2, r, 1'b0);
            got = r;
        end
        repeat (HALF) @(negedge clk);
        cs_n = 1'b1;
        repeat (3 * HALF) @(negedge clk);
    endtask

    task automatic swr(input logic [5:0] a, input logic [7:0] d);
        logic [7:0] g;
        frame(2, {1'b0, a, 1'b1}, d, 8'h00, 1'b0, g);
    endtask

    task automatic srd(input logic [5:0] a, output logic [7:0] d);
        frame(2, {1'b0, a, 1'b0}, 8'h00, 8'h00, 1'b0, d);
    endtask

    task automatic lwr(input logic [9:0] a, input logic [7:0] d);
        logic [7:0] g;
        frame(3, {1'b1, a[9:3]}, {a[2:0], 1'b1, 4'b0}, d, 1'b0, g);
    endtask

    task automatic lrd(input logic [9:0] a, output logic [7:0] d);
        frame(3, {1'b1, a[9:3]}, {a[2:0], 1'b0, 4'b0}, 8'h00, 1'b0, d);
    endtask

    task automatic tx_result(input logic failed, input logic busy);
        tx_failed = failed;
        tx_busy   = busy;
        tx_done   = 1'b1;
        @(negedge clk);
        tx_done   = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_reset_state();
        logic [7:0] d;
        chk("R12 miso", {7'b0, miso}, 8'h00);
        chk("R12 irq_n", {7'b0, irq_n}, 8'h01);
        chk("R12 outputs", {4'b0, tx_start, rf_sm_rst, soft_rst == 3'b0, 1'b0}, 8'h02);
        srd(6'h32, d); chk("R12 mask", d, 8'hFF);
        srd(6'h31, d); chk("R12 flags", d, 8'h00);
        srd(6'h05, d); chk("R12 plain", d, 8'h00);
    endtask

    task automatic t_short_plain();
        logic [7:0] d;
        swr(6'h03, 8'hA5);
        swr(6'h00, 8'h3C);
        swr(6'h07, 8'h81);
        srd(6'h03, d); chk("R1 short 0x03", d, 8'hA5);
        srd(6'h00, d); chk("R1 short 0x00", d, 8'h3C);
        srd(6'h07, d); chk("R1 short 0x07", d, 8'h81);
    endtask

    task automatic t_long_plain();
        logic [7:0] d;
        lwr(10'h201, 8'h5A);
        lwr(10'h207, 8'hC3);
        lrd(10'h201, d); chk("R2 long 0x201", d, 8'h5A);
        lrd(10'h207, d); chk("R2 long 0x207", d, 8'hC3);
        srd(6'h01, d); chk("R2 short 0x01 untouched", d, 8'h00);
    endtask

    task automatic t_unmapped();
        logic [7:0] d;
        swr(6'h20, 8'hFF);
        srd(6'h20, d); chk("R11 short 0x20", d, 8'h00);
        lwr(10'h300, 8'h77);
        lrd(10'h300, d); chk("R11 long 0x300", d, 8'h00);
        lwr(10'h208, 8'h66);
        lrd(10'h208, d); chk("R11 long 0x208", d, 8'h00);
    endtask

    task automatic t_soft_reset();
        logic [7:0] d;
        swr(6'h2A, 8'h05);
        chk("R3 lines after write", {5'b0, soft_rst}, 8'h05);
        srd(6'h2A, d); chk("R3 read while active", d, 8'h05);
        repeat (400) @(negedge clk);
        chk("R3 lines cleared", {5'b0, soft_rst}, 8'h00);
        srd(6'h2A, d); chk("R3 read cleared", d, 8'h00);
        swr(6'h2A, 8'h00);
        chk("R3 zero write no effect", {5'b0, soft_rst}, 8'h00);
    endtask

    task automatic t_rssi();
        logic [7:0] d;
        rssi_level = 8'h47;
        swr(6'h3E, 8'h80);
        srd(6'h3E, d); chk("R4 request pending", d, 8'h80);
        repeat (500) @(negedge clk);
        srd(6'h3E, d); chk("R4 ready", d, 8'h01);
        lrd(10'h210, d); chk("R5 sample", d, 8'h47);
        rssi_level = 8'h10;
        lrd(10'h210, d); chk("R5 held", d, 8'h47);
        lwr(10'h210, 8'hEE);
        lrd(10'h210, d); chk("R5 write ignored", d, 8'h47);
        swr(6'h3E, 8'h80);
        srd(6'h3E, d); chk("R4 ready cleared on restart", d, 8'h80);
        repeat (500) @(negedge clk);
        lrd(10'h210, d); chk("R5 second sample", d, 8'h10);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        swr(6'h32, 8'hF6);
        srd(6'h32, d); chk("R7 mask readback", d, 8'hF6);
        chk("R7 idle high", {7'b0, irq_n}, 8'h01);
        rx_evt = 1'b1; @(negedge clk); rx_evt = 1'b0; @(negedge clk);
        chk("R7 enabled rx asserts", {7'b0, irq_n}, 8'h00);
        srd(6'h31, d); chk("R6 rx flag read", d, 8'h08);
        chk("R7 released after read", {7'b0, irq_n}, 8'h01);
        srd(6'h31, d); chk("R6 cleared by read", d, 8'h00);
        swr(6'h32, 8'hFF);
        tx_result(1'b0, 1'b0);
        chk("R7 masked tx stays high", {7'b0, irq_n}, 8'h01);
        srd(6'h31, d); chk("R6 tx flag read", d, 8'h01);
    endtask

    task automatic t_coincident_clear();
        logic [7:0] d;
        srd(6'h31, d);
        frame(2, {1'b0, 6'h31, 1'b0}, 8'h00, 8'h00, 1'b1, d);
        chk("R6 read before coincident event", d, 8'h00);
        srd(6'h31, d); chk("R6 coincident event kept", d, 8'h08);
    endtask

    task automatic t_tx_status();
        logic [7:0] d;
        tx_result(1'b0, 1'b0);
        srd(6'h24, d); chk("R8 success", d, 8'h00);
        tx_result(1'b1, 1'b1);
        srd(6'h24, d); chk("R8 busy channel", d, 8'h21);
        tx_result(1'b1, 1'b0);
        srd(6'h24, d); chk("R8 retries exhausted", d, 8'h01);
        tx_result(1'b0, 1'b1);
        srd(6'h24, d); chk("R8 busy without fail", d, 8'h00);
        swr(6'h24, 8'hFF);
        srd(6'h24, d); chk("R8 write ignored", d, 8'h00);
    endtask

    task automatic t_tx_start();
        logic [7:0] d;
        int base;
        base = n_start;
        swr(6'h1B, 8'h01);
        chk("R9 one pulse", 8'(n_start - base), 8'h01);
        srd(6'h1B, d); chk("R9 reads zero", d, 8'h00);
        swr(6'h1B, 8'hFE);
        chk("R9 no pulse without bit0", 8'(n_start - base), 8'h01);
    endtask

    task automatic t_rf_ctl();
        logic [7:0] d;
        swr(6'h36, 8'h04);
        chk("R10 line set", {7'b0, rf_sm_rst}, 8'h01);
        srd(6'h36, d); chk("R10 readback", d, 8'h04);
        swr(6'h36, 8'h00);
        chk("R10 line cleared", {7'b0, rf_sm_rst}, 8'h00);
        swr(6'h36, 8'hFB);
        srd(6'h36, d); chk("R10 other bits dropped", d, 8'h00);
        swr(6'h36, 8'hFF);
        srd(6'h36, d); chk("R10 only bit2 kept", d, 8'h04);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        t_reset_state();
        t_short_plain();
        t_long_plain();
        t_unmapped();
        t_soft_reset();
        t_rssi();
        t_irq();
        t_coincident_clear();
        t_tx_status();
        t_tx_start();
        t_rf_ctl();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule